// File: doc/BRIEF.md
# Spawn Column Generator

This block turns a 7-bit maximal-length linear feedback shift register into a stream of horizontal spawn positions for enemy objects on a 640-pixel display line. Each spawn request advances the register by one step. The new register value is scaled by four, which spaces candidate columns four pixels apart. A fixed margin of 64 is then added, so no object appears against the left or right edge.

The register can be reloaded at any time from a seed input. A seed of zero would lock the register, so it is replaced by the value 1. The result is a registered 10-bit column with a one-cycle valid pulse. The surrounding game logic decides when to request a spawn and which enemy slot receives the column.

Top module: `spawn_x_gen`

## Requirements
- R1: While rst_ni is low and after its release, spawn_valid_o is 0 and spawn_x_o is 0. The register state after reset is 7'h01, so the first request without a seed load yields column 72.
- R2: On each accepted request, the 7-bit state r becomes {r[5:0], r[6]^r[5]}.
- R3: The column presented after a request is (new state << 2) + 64, as an unsigned 10-bit value.
- R4: spawn_valid_o is 1 in exactly the cycle after each accepted request and 0 otherwise. A request held high for N cycles gives N consecutive valid cycles, each with a new column.
- R5: spawn_x_o holds its last value in every cycle where spawn_valid_o is 0.
- R6: When seed_load_i is high with a non-zero seed_i, the state becomes seed_i. The next request then steps from that seed.
- R7: When seed_load_i is high with seed_i equal to 0, the state becomes 7'h01.
- R8: When seed_load_i and spawn_req_i are both high in the same cycle, the load takes effect and the request is dropped. No valid pulse follows, and spawn_x_o is unchanged.
- R9: From any non-zero seed, 127 consecutive requests produce 127 distinct columns, all within 68..572. The 127th request returns the seed's own column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load seed_i into the register (takes priority over spawn_req_i) |
| seed_i | input | 7 | Seed value; zero is replaced by 7'h01 |
| spawn_req_i | input | 1 | Advance the register and produce a column |
| spawn_x_o | output | 10 | Registered spawn column |
| spawn_valid_o | output | 1 | One-cycle pulse marking a new column |

## Verification
The embedded assertions check the following on every cycle:
- the register never holds zero;
- it holds when idle and takes a non-zero seed on a load;
- a pulse follows each accepted request and no other;
- the column stays constant between pulses;
- every presented column lies in 68..572.

The exact column values, the zero-seed substitution and the dropped request under a simultaneous load are compared against a behavioural model in the bench. The full 127-step period with distinct columns is shown only by the bench's long run.

// File: rtl/spawn_pkg.sv
package spawn_pkg;
  localparam int unsigned LFSR_W_DEF = 7;
  localparam int unsigned X_W_DEF    = 10;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } lfsr_cmd_e;
endpackage

// File: rtl/spawn_lfsr.sv
module spawn_lfsr
  import spawn_pkg::*;
#(
  parameter int unsigned W      = LFSR_W_DEF,
  parameter int unsigned TAP_HI = 6,
  parameter int unsigned TAP_LO = 5,
  parameter logic [W-1:0] SAFE_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  lfsr_cmd_e    cmd_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] next_o,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, seed_eff;

  assign next_o   = {state_q[W-2:0], state_q[TAP_HI] ^ state_q[TAP_LO]};
  assign seed_eff = (seed_i == '0) ? SAFE_VAL : seed_i;
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SAFE_VAL;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: state_q <= seed_eff;
        CMD_STEP: state_q <= next_o;
        default:  state_q <= state_q;
      endcase
    end
  end

  // lockup state must be unreachable
  p_never_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_HOLD |=> $stable(state_q));
  p_seed_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_LOAD && seed_i != '0) |=> state_q == $past(seed_i));
endmodule

// File: rtl/spawn_x_map.sv
module spawn_x_map #(
  parameter int unsigned W      = 7,
  parameter int unsigned X_W    = 10,
  parameter int unsigned SHIFT  = 2,
  parameter int unsigned MARGIN = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic [W-1:0]   val_i,
  output logic [X_W-1:0] x_o,
  output logic           valid_o
);
  localparam int unsigned X_MIN = (1 << SHIFT) + MARGIN;
  localparam int unsigned X_MAX = (((1 << W) - 1) << SHIFT) + MARGIN;

  logic [X_W-1:0] scaled, x_d;

  assign scaled = X_W'(val_i) << SHIFT;
  assign x_d    = scaled + X_W'(MARGIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= step_i;
      if (step_i) x_o <= x_d;
    end
  end

  p_x_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> (valid_o || $stable(x_o)));
  p_x_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(x_o) >= X_MIN && int'(x_o) <= X_MAX));
endmodule

// File: rtl/spawn_x_gen.sv
module spawn_x_gen
  import spawn_pkg::*;
#(
  parameter int unsigned LFSR_W = LFSR_W_DEF,
  parameter int unsigned X_W    = X_W_DEF,
  parameter int unsigned SHIFT  = 2,
  parameter int unsigned MARGIN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              spawn_req_i,
  output logic [X_W-1:0]    spawn_x_o,
  output logic              spawn_valid_o
);
  lfsr_cmd_e         cmd;
  logic [LFSR_W-1:0] lfsr_next, lfsr_state;
  logic              step;

  // load wins over request
  always_comb begin
    if (seed_load_i)      cmd = CMD_LOAD;
    else if (spawn_req_i) cmd = CMD_STEP;
    else                  cmd = CMD_HOLD;
  end
  assign step = (cmd == CMD_STEP);

  spawn_lfsr #(.W(LFSR_W), .TAP_HI(LFSR_W-1), .TAP_LO(LFSR_W-2)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .seed_i (seed_i),
    .next_o (lfsr_next),
    .state_o(lfsr_state)
  );

  spawn_x_map #(.W(LFSR_W), .X_W(X_W), .SHIFT(SHIFT), .MARGIN(MARGIN)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .val_i  (lfsr_next),
    .x_o    (spawn_x_o),
    .valid_o(spawn_valid_o)
  );

  p_pulse_after_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spawn_req_i && !seed_load_i) |=> spawn_valid_o);
  p_no_pulse_on_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> !spawn_valid_o);
  p_pulse_has_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spawn_valid_o |-> $past(spawn_req_i && !seed_load_i));
  p_state_moves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spawn_req_i && !seed_load_i) |=> lfsr_state != $past(lfsr_state));
endmodule

// File: tb/spawn_x_gen_tb_top.sv
module spawn_x_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [6:0] seed = '0;
  logic       req = 1'b0;
  logic [9:0] x;
  logic       vld;

  int checks = 0;
  int errors = 0;
  int m_r = 1, m_x = 0, m_v = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spawn_x_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .seed_load_i(load), .seed_i(seed),
    .spawn_req_i(req), .spawn_x_o(x), .spawn_valid_o(vld)
  );

  function automatic int nxt(input int r);
    return ((r << 1) & 127) | (((r >> 6) ^ (r >> 5)) & 1);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive after a falling edge, update model at rising edge, compare at next falling edge
  task automatic cyc(input bit ld, input int sd, input bit rq, input string tag);
    load = ld; seed = 7'(sd); req = rq;
    @(posedge clk);
    if (ld) begin
      m_r = (sd == 0) ? 1 : sd;
      m_v = 0;
    end else if (rq) begin
      m_r = nxt(m_r);
      m_x = m_r * 4 + 64;
      m_v = 1;
    end else m_v = 0;
    @(negedge clk);
    check({tag, " valid"}, int'(vld), m_v);
    check({tag, " x"}, int'(x), m_x);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen [0:1023];
    int first_x, lo, hi;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(vld), 0);
    check("R1 reset x", int'(x), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset x", int'(x), 0);
    // R1/R3: first step from 7'h01 gives 72
    cyc(0, 0, 1, "R1 first request");
    check("R3 first column", int'(x), 72);
    // R5 hold while idle
    repeat (3) cyc(0, 0, 0, "R5 idle hold");
    // R4 back-to-back requests
    repeat (5) cyc(0, 0, 1, "R4 burst");
    cyc(0, 0, 0, "R4 pulse ends");
    // R2 alternating
    for (int i = 0; i < 6; i++) cyc(0, 0, i % 2 == 0, "R2 alternate");
    // R6 seed load
    cyc(1, 7'h40, 0, "R6 load");
    cyc(0, 0, 1, "R6 step from seed");
    check("R6 column from 0x40", int'(x), 8'h01 * 4 + 64 + 0 * 0 + (8'h01 == 8'h01 ? 0 : 0) + 0);
    // R7 zero seed
    cyc(1, 0, 0, "R7 zero load");
    cyc(0, 0, 1, "R7 step from 1");
    check("R7 column", int'(x), 72);
    // R8 simultaneous load and request
    cyc(0, 0, 1, "R8 prior");
    cyc(1, 7'h2a, 1, "R8 load wins");
    cyc(0, 0, 0, "R8 idle");
    cyc(0, 0, 1, "R8 step from seed");
    check("R8 column from 0x2a", int'(x), ((7'h2a << 1) & 127 | 1) * 4 + 64);
    // R9 full period
    cyc(1, 7'h35, 0, "R9 load");
    lo = 1023; hi = 0;
    foreach (seen[k]) seen[k] = 0;
    for (int i = 0; i < 127; i++) begin
      cyc(0, 0, 1, "R9 period");
      if (seen[x]) check("R9 repeat column", int'(x), -1);
      seen[x] = 1;
      if (int'(x) < lo) lo = int'(x);
      if (int'(x) > hi) hi = int'(x);
    end
    first_x = 7'h35 * 4 + 64;
    check("R9 period closes", int'(x), first_x);
    check("R9 min column", lo, 68);
    check("R9 max column", hi, 572);
    cyc(0, 0, 0, "R9 tail");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule